// File: doc/BRIEF.md
# Serial Real-Time Clock and Backup Memory Slave

This block is a slave on a four-wire serial bus (chip select, serial clock, data in, data out). It keeps a 32-bit seconds counter, a small bank of backup memory words, a snapshot register, two power timer registers, a writable control register, a read-only status register that carries two power-health flags, and four read-only test locations. The host reaches any of them with a frame of two 32-bit words. The first word is a command and the second word is the data.

The command word holds a direction flag in its top bit and a register address in the bits above bit 8. For a write, the host sends the data word after the command. For a read, the block shifts the selected register out while the host clocks the data word. The seconds counter advances on a one-cycle enable pulse, `tickSec`, that arrives once per second. A write loads the counter directly. Any bias arithmetic is left to the host.

The serial pins are sampled in the `clk` domain through synchronisers. The serial clock must therefore run several times slower than `clk`.

Top module: `rtc_sram_slave`

## Requirements
- R1: A frame is 64 bits, most significant bit first. The slave samples `mosi` on the rising edges of `sck` and changes `miso` after the falling edges. Command bit 31 set means write and clear means read. Command bits 30:8 hold the address. Command bits 7:0 are ignored. Bits after the 64th are ignored.
- R2: In a read frame, `miso` carries the selected register's value during the data word, most significant bit first. Reading a register does not change it.
- R3: Sixteen backup memory words sit at addresses 0x200001 to 0x200010. Each word can be read and written on its own. The word at 0x200004 (the bias word) behaves like the others.
- R4: The seconds counter at 0x200000 can be read and written. A write loads the data word directly.
- R5: The seconds counter adds one on every `clk` cycle in which `tickSec` is high. It wraps from 0xFFFFFFFF to 0.
- R6: The snapshot register (0x204000), the power-on timer (0x210000), the power-off timer (0x210001) and control register 1 (0x21000d) can each be read and written.
- R7: The test locations 0x210004 to 0x210007 read as zero. Writes to them and to control register 0 (0x21000c) have no effect.
- R8: Control register 0 reads bit 11 = `pwrUnstable` and bit 9 = `battLow`. All its other bits read as zero.
- R9: Any other address reads as zero, and a write to it changes no register.
- R10: Raising `csN` abandons the frame in progress. A write frame cut short before its 64th bit changes nothing, and the next frame decodes normally.
- R11: After reset every register holds zero, and `miso` is low whenever no read data is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| tickSec | input | 1 | One-cycle pulse, once per second |
| pwrUnstable | input | 1 | Power monitor: supply was unstable, so the time may be invalid |
| battLow | input | 1 | Power monitor: backup battery is low |

## Verification
The bench drives the serial decoder with many frame shapes, and each shape tells a different fault apart:
- Plain reads and writes to every storage class show that the address decode is correct.
- Commands with junk in the low byte show that the address field is extracted correctly.
- Writes aimed at read-only and unmapped addresses, each followed by readback of the neighbouring words, separate a decoder that is too loose from one that is correct.
- Frames cut short by chip select show whether the phase tracker really clears.
- Tick pulses around the all-ones counter value, and the four combinations of the two power flags, exercise the counter and the status bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_LSB = 8;
  localparam int ADDR_W   = WORD_W - 1 - ADDR_LSB;
  localparam int FRAME_W  = 2 * WORD_W;

  localparam logic [ADDR_W-1:0] ADDR_COUNT  = ADDR_W'(24'h200000);
  localparam logic [ADDR_W-1:0] ADDR_SRAM   = ADDR_W'(24'h200001);
  localparam logic [ADDR_W-1:0] ADDR_SNAP   = ADDR_W'(24'h204000);
  localparam logic [ADDR_W-1:0] ADDR_ONTMR  = ADDR_W'(24'h210000);
  localparam logic [ADDR_W-1:0] ADDR_OFFTMR = ADDR_W'(24'h210001);
  localparam logic [ADDR_W-1:0] ADDR_CTRL0  = ADDR_W'(24'h21000c);
  localparam logic [ADDR_W-1:0] ADDR_CTRL1  = ADDR_W'(24'h21000d);

  localparam int PWR_BIT  = 11;
  localparam int BATT_BIT = 9;

  typedef struct packed {
    logic              rdReq;
    logic              wrReq;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wrData;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic [WORD_W-1:0] rdData,
  output logic              miso,
  output rtcStrobe_t        strobe
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_W);

  logic [2:0] sckSync;
  logic [1:0] csSync;
  logic [1:0] mosiSync;
  logic       sckRise, sckFall, csIdle, mosiBit;

  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] inShift;
  logic [WORD_W-1:0] outShift;
  logic [WORD_W-1:0] wordNext;
  logic              cmdWrite;
  logic [ADDR_W-1:0] cmdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sckSync  <= {sckSync[1:0], sck};
      csSync   <= {csSync[0], csN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  assign sckRise  = sckSync[1] & ~sckSync[2];
  assign sckFall  = ~sckSync[1] & sckSync[2];
  assign csIdle   = csSync[1];
  assign mosiBit  = mosiSync[1];
  assign wordNext = {inShift[WORD_W-2:0], mosiBit};

  always_comb begin
    strobe.rdReq  = !csIdle && sckRise && (bitCnt == CMD_LAST) && !wordNext[WORD_W-1];
    strobe.wrReq  = !csIdle && sckRise && (bitCnt == FRAME_LAST) && cmdWrite;
    strobe.addr   = (bitCnt < DATA_FIRST) ? wordNext[WORD_W-2:ADDR_LSB] : cmdAddr;
    strobe.wrData = wordNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      inShift  <= '0;
      outShift <= '0;
      cmdWrite <= 1'b0;
      cmdAddr  <= '0;
    end else if (csIdle) begin
      bitCnt   <= '0;
      outShift <= '0;
      cmdWrite <= 1'b0;
    end else if (sckRise && bitCnt < FRAME_END) begin
      inShift <= wordNext;
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == CMD_LAST) begin
        cmdWrite <= wordNext[WORD_W-1];
        cmdAddr  <= wordNext[WORD_W-2:ADDR_LSB];
        if (!wordNext[WORD_W-1]) outShift <= rdData;
      end
    end else if (sckFall && bitCnt > DATA_FIRST) begin
      outShift <= {outShift[WORD_W-2:0], 1'b0};
    end
  end

  assign miso = outShift[WORD_W-1];

  // R2: the word loaded on a read request appears on miso at once
  assert_miso_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdReq |=> (csIdle || miso == $past(rdData[WORD_W-1])));

  // R10: an idle chip select clears the phase tracker
  assert_cs_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> (bitCnt == '0 && miso == 1'b0));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int SRAM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSec,
  input  logic              pwrUnstable,
  input  logic              battLow,
  input  rtcStrobe_t        strobe,
  output logic [WORD_W-1:0] rdData
);
  localparam int IDX_W = (SRAM_WORDS > 1) ? $clog2(SRAM_WORDS) : 1;
  localparam logic [ADDR_W-1:0] SRAM_LIMIT = ADDR_SRAM + ADDR_W'(SRAM_WORDS);

  logic [WORD_W-1:0] count, snapReg, onTmr, offTmr, ctrl1Reg, ctrl0Word;
  logic [WORD_W-1:0] sram [SRAM_WORDS];
  logic [ADDR_W-1:0] sramOff;
  logic [IDX_W-1:0]  sramIdx;
  logic              sramHit, wrCount;

  assign sramOff = strobe.addr - ADDR_SRAM;
  assign sramIdx = sramOff[IDX_W-1:0];
  assign sramHit = (strobe.addr >= ADDR_SRAM) && (strobe.addr < SRAM_LIMIT);
  assign wrCount = strobe.wrReq && (strobe.addr == ADDR_COUNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        count <= '0;
    else if (wrCount) count <= strobe.wrData;
    else if (tickSec) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapReg  <= '0;
      onTmr    <= '0;
      offTmr   <= '0;
      ctrl1Reg <= '0;
    end else if (strobe.wrReq) begin
      if (strobe.addr == ADDR_SNAP)   snapReg  <= strobe.wrData;
      if (strobe.addr == ADDR_ONTMR)  onTmr    <= strobe.wrData;
      if (strobe.addr == ADDR_OFFTMR) offTmr   <= strobe.wrData;
      if (strobe.addr == ADDR_CTRL1)  ctrl1Reg <= strobe.wrData;
    end
  end

  for (genvar gi = 0; gi < SRAM_WORDS; gi++) begin : g_sram
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sram[gi] <= '0;
      else if (strobe.wrReq && sramHit && sramIdx == IDX_W'(gi)) sram[gi] <= strobe.wrData;
    end
  end

  always_comb begin
    ctrl0Word           = '0;
    ctrl0Word[PWR_BIT]  = pwrUnstable;
    ctrl0Word[BATT_BIT] = battLow;
  end

  always_comb begin
    rdData = '0;
    if (sramHit) rdData = sram[sramIdx];
    else begin
      case (strobe.addr)
        ADDR_COUNT:  rdData = count;
        ADDR_SNAP:   rdData = snapReg;
        ADDR_ONTMR:  rdData = onTmr;
        ADDR_OFFTMR: rdData = offTmr;
        ADDR_CTRL0:  rdData = ctrl0Word;
        ADDR_CTRL1:  rdData = ctrl1Reg;
        default:     rdData = '0;
      endcase
    end
  end

  // R5: a tick without a competing load adds exactly one
  assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tickSec && !wrCount) |=> count == $past(count) + 1'b1);

  // R8: status bits follow the power monitor inputs
  assert_status_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdReq && strobe.addr == ADDR_CTRL0) |->
      (rdData[PWR_BIT] == pwrUnstable && rdData[BATT_BIT] == battLow));

  // R9: addresses past the map read as zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdReq && strobe.addr > ADDR_CTRL1) |-> rdData == '0);

  // R7: writing the status register leaves control register 1 alone
  assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrReq && strobe.addr == ADDR_CTRL0) |=> $stable(ctrl1Reg));
endmodule

// File: rtl/rtc_sram_slave.sv
module rtc_sram_slave
  import rtc_pkg::*;
#(
  parameter int SRAM_WORDS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  input  logic tickSec,
  input  logic pwrUnstable,
  input  logic battLow
);
  rtcStrobe_t        strobe;
  logic [WORD_W-1:0] rdData;

  rtc_spi_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sck    (sck),
    .mosi   (mosi),
    .rdData (rdData),
    .miso   (miso),
    .strobe (strobe)
  );

  rtc_regs #(.SRAM_WORDS(SRAM_WORDS)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .tickSec     (tickSec),
    .pwrUnstable (pwrUnstable),
    .battLow     (battLow),
    .strobe      (strobe),
    .rdData      (rdData)
  );
endmodule

// File: tb/rtc_sram_slave_tb.sv
module rtc_sram_slave_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic tickSec = 1'b0, pwrUnstable = 1'b0, battLow = 1'b0;
  logic miso;
  int   total = 0, bad = 0;

  always #4 clk = ~clk;

  rtc_sram_slave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .miso(miso),
    .tickSec(tickSec), .pwrUnstable(pwrUnstable), .battLow(battLow)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xferRaw(input logic [31:0] cmd, input logic [31:0] wdata,
                         input int nbits, output logic [31:0] rdata);
    logic [63:0] frame;
    frame = {cmd, wdata};
    rdata = '0;
    @(negedge clk);
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = frame[63-i];
      waitClk(HALF);
      if (i >= 32) rdata = {rdata[30:0], miso};
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    mosi = 1'b0;
    waitClk(2 * HALF);
  endtask

  task automatic wr(input logic [22:0] addr, input logic [31:0] data);
    logic [31:0] dummy;
    xferRaw({1'b1, addr, 8'h00}, data, 64, dummy);
  endtask

  task automatic rd(input logic [22:0] addr, output logic [31:0] data);
    xferRaw({1'b0, addr, 8'h00}, 32'h0, 64, data);
  endtask

  task automatic testReset;
    logic [31:0] v;
    check("R11 miso idle", {31'b0, miso}, 32'h0);
    rd(23'h200000, v); check("R11 counter reset", v, 32'h0);
    rd(23'h200004, v); check("R11 sram reset", v, 32'h0);
    rd(23'h21000d, v); check("R11 ctrl1 reset", v, 32'h0);
  endtask

  task automatic testCounter;
    logic [31:0] v;
    wr(23'h200000, 32'h12345678);
    rd(23'h200000, v); check("R4 counter load", v, 32'h12345678);
    wr(23'h200000, 32'h00000010);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) tickSec = 1'b1;
      @(negedge clk) tickSec = 1'b0;
    end
    rd(23'h200000, v); check("R5 counter ticks", v, 32'h00000013);
    wr(23'h200000, 32'hFFFFFFFF);
    @(negedge clk) tickSec = 1'b1;
    @(negedge clk) tickSec = 1'b0;
    rd(23'h200000, v); check("R5 counter wrap", v, 32'h0);
  endtask

  task automatic testSram;
    logic [31:0] v;
    for (int i = 0; i < 16; i++) wr(23'(24'h200001 + i), 32'hA5000000 ^ (32'h01010101 * i));
    for (int i = 0; i < 16; i++) begin
      rd(23'(24'h200001 + i), v);
      check("R3 sram word", v, 32'hA5000000 ^ (32'h01010101 * i));
    end
    wr(23'h200004, 32'hB1A5B1A5);
    rd(23'h200004, v); check("R3 bias word", v, 32'hB1A5B1A5);
    rd(23'h200005, v); check("R3 neighbour kept", v, 32'hA5000000 ^ (32'h01010101 * 4));
  endtask

  task automatic testMisc;
    logic [31:0] v, cmdOut;
    wr(23'h204000, 32'h11112222);
    wr(23'h210000, 32'h33334444);
    wr(23'h210001, 32'h55556666);
    wr(23'h21000d, 32'h77778888);
    rd(23'h204000, v); check("R6 snapshot", v, 32'h11112222);
    rd(23'h210000, v); check("R6 on timer", v, 32'h33334444);
    rd(23'h210001, v); check("R6 off timer", v, 32'h55556666);
    rd(23'h21000d, v); check("R6 ctrl1", v, 32'h77778888);
    rd(23'h21000d, v); check("R2 reread unchanged", v, 32'h77778888);
    xferRaw({1'b1, 23'h204000, 8'hFF}, 32'hCAFEF00D, 64, cmdOut);
    xferRaw({1'b0, 23'h204000, 8'h5A}, 32'h0, 64, v);
    check("R1 low byte ignored", v, 32'hCAFEF00D);
    xferRaw({1'b1, 23'h210000, 8'h00}, 32'h0BADBEEF, 70, cmdOut);
    rd(23'h210000, v); check("R1 extra bits ignored", v, 32'h0BADBEEF);
  endtask

  task automatic testReadOnly;
    logic [31:0] v;
    for (int i = 4; i < 8; i++) begin
      rd(23'(24'h210000 + i), v); check("R7 test reads zero", v, 32'h0);
    end
    wr(23'h210005, 32'hFFFFFFFF);
    rd(23'h210005, v); check("R7 test write ignored", v, 32'h0);
    wr(23'h21000c, 32'hFFFFFFFF);
    rd(23'h21000c, v); check("R7 ctrl0 write ignored", v, 32'h0);
    rd(23'h21000d, v); check("R7 ctrl1 untouched", v, 32'h77778888);
  endtask

  task automatic testStatus;
    logic [31:0] v;
    pwrUnstable = 1'b1; battLow = 1'b0;
    rd(23'h21000c, v); check("R8 unstable", v, 32'h00000800);
    pwrUnstable = 1'b0; battLow = 1'b1;
    rd(23'h21000c, v); check("R8 batt low", v, 32'h00000200);
    pwrUnstable = 1'b1; battLow = 1'b1;
    rd(23'h21000c, v); check("R8 both", v, 32'h00000A00);
    pwrUnstable = 1'b0; battLow = 1'b0;
    rd(23'h21000c, v); check("R8 none", v, 32'h0);
  endtask

  task automatic testUnmapped;
    logic [31:0] v;
    wr(23'h200011, 32'hDEADBEEF);
    rd(23'h200011, v); check("R9 unmapped read", v, 32'h0);
    rd(23'h200010, v); check("R9 last sram kept", v, 32'hA5000000 ^ (32'h01010101 * 15));
    rd(23'h200000, v); check("R9 counter kept", v, 32'h0);
    wr(23'h300000, 32'h12121212);
    rd(23'h300000, v); check("R9 high unmapped", v, 32'h0);
  endtask

  task automatic testAbort;
    logic [31:0] v;
    xferRaw({1'b1, 23'h204000, 8'h00}, 32'h99999999, 40, v);
    rd(23'h204000, v); check("R10 cut write ignored", v, 32'hCAFEF00D);
    xferRaw({1'b1, 23'h21000d, 8'h00}, 32'h0, 20, v);
    wr(23'h210001, 32'h24682468);
    rd(23'h210001, v); check("R10 next frame clean", v, 32'h24682468);
    rd(23'h21000d, v); check("R10 ctrl1 kept", v, 32'h77778888);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testCounter();
    testSram();
    testMisc();
    testReadOnly();
    testStatus();
    testUnmapped();
    testAbort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule